// File: doc/BRIEF.md
# Accumulator Processor with Phased Fetch-Execute Control

This block is a small 8-bit processor built around a single accumulator. It has one 32-word by 8-bit memory that holds both the program and its data. Its registers are a program counter, a memory address register, an instruction register, an operand latch and the accumulator. A phase sequencer moves the machine through six steps, one register transfer per clock cycle. The first five steps fetch the instruction word and then its operand from the direct address in that word. The sixth step executes one of eight opcodes.

Each instruction word holds a 3-bit opcode in bits [7:5] and a 5-bit direct address in bits [4:0]. While reset is asserted, a preload port fills the memory with a program. After reset is released, the processor runs from address 0 until it executes a halt. The accumulator and the halt flag are visible on output ports, so a test can follow the program's progress.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a rising edge, the accumulator, program counter and halt flag clear to 0 at that edge. Memory contents are kept.
- R2: The preload port writes `pre_data` to `pre_addr` only at edges where `rst` is high. A write request while `rst` is low leaves memory unchanged.
- R3: Every instruction takes exactly six clock cycles. The result of the n-th instruction (n starting at 1) is visible on `acc_out` after 6n rising edges counted from the first edge with `rst` low.
- R4: Bits [7:5] of an instruction word are the opcode and bits [4:0] are the operand address. Opcode 000 (load) sets ACC to mem[addr].
- R5: Opcode 001 (store) writes ACC to mem[addr] and leaves ACC unchanged.
- R6: Opcode 010 (add) sets ACC to (ACC + mem[addr]) mod 256. The carry-out is dropped.
- R7: Opcode 011 (complement) sets ACC to the bitwise inverse of mem[addr].
- R8: Opcode 100 (branch if not negative) sets PC to addr when ACC bit 7 is 0. Otherwise execution continues with the next word.
- R9: Opcode 101 shifts ACC left by one bit and opcode 110 shifts ACC right by one bit. In both cases the vacated bit is 0 and the operand is ignored.
- R10: Opcode 111 (halt) sets `halted`. After that, ACC, PC and memory stay frozen until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also enables preload |
| pre_we | input | 1 | Preload write strobe (honoured only during reset) |
| pre_addr | input | 5 | Preload word address |
| pre_data | input | 8 | Preload word value |
| halted | output | 1 | High after a halt instruction executes |
| acc_out | output | 8 | Current accumulator value |

## Verification
The assertions check the following on every cycle: the phase order and the six-step wrap, the clearing done by reset, a store leaving the accumulator untouched, the target of a taken branch, the zero fill of both shifts, and the freeze after a halt. Other behaviours need whole programs to show them. These are the operand values each opcode produces, carry loss on add, a branch not taken when the sign bit is set, a stored value read back by a later load, and a preload ignored outside reset. The bench's scenarios cover these, comparing the accumulator at each instruction boundary.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int WORD_W = 8;
    localparam int OPC_W  = 3;
    localparam int LOC_W  = WORD_W - OPC_W;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 3'b000,
        OP_STORE = 3'b001,
        OP_ADD   = 3'b010,
        OP_INV   = 3'b011,
        OP_BRPOS = 3'b100,
        OP_SHL   = 3'b101,
        OP_SHR   = 3'b110,
        OP_STOP  = 3'b111
    } opcode_e;

    typedef enum logic [2:0] {
        PH_PC2MAR  = 3'd0,
        PH_MEM2IR  = 3'd1,
        PH_PCINC   = 3'd2,
        PH_IR2MAR  = 3'd3,
        PH_MEM2LAT = 3'd4,
        PH_EXEC    = 3'd5
    } phase_e;

    typedef struct packed {
        logic ld_acc;
        logic wr_mem;
        logic br_test;
        logic stop;
    } exec_ctl_t;

    function automatic exec_ctl_t decode_op(input opcode_e op);
        exec_ctl_t c;
        c = '0;
        unique case (op)
            OP_LOAD, OP_ADD, OP_INV, OP_SHL, OP_SHR: c.ld_acc = 1'b1;
            OP_STORE: c.wr_mem  = 1'b1;
            OP_BRPOS: c.br_test = 1'b1;
            OP_STOP:  c.stop    = 1'b1;
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   stop_req,
    output phase_e phase,
    output logic   halted
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_PC2MAR;
            halted <= 1'b0;
        end else if (!halted) begin
            if (phase == PH_EXEC) begin
                phase <= PH_PC2MAR;
                if (stop_req) halted <= 1'b1;
            end else begin
                phase <= phase_e'(phase + 3'd1);
            end
        end
    end
endmodule

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] opnd,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        unique case (op)
            OP_LOAD: result = opnd;
            OP_ADD:  result = acc + opnd;
            OP_INV:  result = ~opnd;
            OP_SHL:  result = {acc[DATA_W-2:0], 1'b0};
            OP_SHR:  result = {1'b0, acc[DATA_W-1:1]};
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int ADDR_W = LOC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_we,
    input  logic [ADDR_W-1:0] pre_addr,
    input  logic [DATA_W-1:0] pre_data,
    output logic              halted,
    output logic [DATA_W-1:0] acc_out
);
    localparam int SIGN_BIT = DATA_W - 1;

    phase_e            phase_q;
    logic [ADDR_W-1:0] pc_q, mar_q;
    logic [DATA_W-1:0] ir_q, lat_q, acc_q;
    logic [DATA_W-1:0] mem_rd, alu_res;
    opcode_e           op;
    exec_ctl_t         ctl;
    logic              in_exec;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_wa;
    logic [DATA_W-1:0] mem_wd;

    assign op      = opcode_e'(ir_q[DATA_W-1 -: OPC_W]);
    assign ctl     = decode_op(op);
    assign in_exec = (phase_q == PH_EXEC) && !halted;

    // preload owns the write port during reset; store owns it otherwise
    always_comb begin
        if (rst) begin
            mem_we = pre_we;
            mem_wa = pre_addr;
            mem_wd = pre_data;
        end else begin
            mem_we = in_exec && ctl.wr_mem;
            mem_wa = mar_q;
            mem_wd = acc_q;
        end
    end

    acc_cpu_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .stop_req (ctl.stop),
        .phase    (phase_q),
        .halted   (halted)
    );

    acc_cpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_wa),
        .wdata (mem_wd),
        .raddr (mar_q),
        .rdata (mem_rd)
    );

    acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
        .op     (op),
        .acc    (acc_q),
        .opnd   (lat_q),
        .result (alu_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= '0;
            mar_q <= '0;
            ir_q  <= '0;
            lat_q <= '0;
            acc_q <= '0;
        end else if (!halted) begin
            unique case (phase_q)
                PH_PC2MAR:  mar_q <= pc_q;
                PH_MEM2IR:  ir_q  <= mem_rd;
                PH_PCINC:   pc_q  <= pc_q + 1'b1;
                PH_IR2MAR:  mar_q <= ir_q[ADDR_W-1:0];
                PH_MEM2LAT: lat_q <= mem_rd;
                PH_EXEC: begin
                    if (ctl.ld_acc) acc_q <= alu_res;
                    if (ctl.br_test && !acc_q[SIGN_BIT]) pc_q <= ir_q[ADDR_W-1:0];
                end
                default: ;
            endcase
        end
    end

    assign acc_out = acc_q;
endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
    import acc_cpu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst,
    input phase_e            phase,
    input logic              halted,
    input logic [DATA_W-1:0] ir,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] acc
);
    logic [OPC_W-1:0] opc;
    logic             ex;
    assign opc = ir[DATA_W-1 -: OPC_W];
    assign ex  = (phase == PH_EXEC) && !halted;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (acc == '0 && pc == '0 && !halted && phase == PH_PC2MAR));

    a_r3_phase_step: assert property (@(posedge clk) disable iff (rst)
        (!halted && phase != PH_EXEC) |=> (phase == phase_e'($past(phase) + 3'd1)));

    a_r3_exec_wraps: assert property (@(posedge clk) disable iff (rst)
        ex |=> (phase == PH_PC2MAR));

    a_r5_store_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        (ex && opc == OP_STORE) |=> $stable(acc));

    a_r8_branch_target: assert property (@(posedge clk) disable iff (rst)
        (ex && opc == OP_BRPOS && !acc[DATA_W-1]) |=> (pc == $past(ir[ADDR_W-1:0])));

    a_r9_shl_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (ex && opc == OP_SHL) |=> (acc[0] == 1'b0));

    a_r9_shr_zero_fill: assert property (@(posedge clk) disable iff (rst)
        (ex && opc == OP_SHR) |=> (acc[DATA_W-1] == 1'b0));

    a_r10_halt_freezes: assert property (@(posedge clk) disable iff (rst)
        halted |=> (halted && $stable(acc) && $stable(pc)));
endmodule

bind acc_cpu acc_cpu_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .phase  (phase_q),
    .halted (halted),
    .ir     (ir_q),
    .pc     (pc_q),
    .acc    (acc_q)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
    localparam int CYC_PER_INSN = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pre_we = 1'b0;
    logic [4:0] pre_addr = '0;
    logic [7:0] pre_data = '0;
    logic       halted;
    logic [7:0] acc_out;

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        logic [7:0] acc;
        logic       hlt;
        string      req;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    acc_cpu u_dut (
        .clk      (clk),
        .rst      (rst),
        .pre_we   (pre_we),
        .pre_addr (pre_addr),
        .pre_data (pre_data),
        .halted   (halted),
        .acc_out  (acc_out)
    );

    task automatic check(input string req, input logic [7:0] act_acc, input logic act_h,
                         input logic [7:0] exp_acc, input logic exp_h);
        n_run++;
        if (act_acc !== exp_acc || act_h !== exp_h) begin
            n_fail++;
            $display("FAIL %s: acc=%02h halted=%0b expected acc=%02h halted=%0b",
                     req, act_acc, act_h, exp_acc, exp_h);
        end
    endtask

    // driver side: queue the expected state at one instruction boundary
    task automatic expect_slot(input logic [7:0] a, input logic h, input string r);
        exp_t e;
        e.acc = a; e.hlt = h; e.req = r;
        sb.push_back(e);
    endtask

    task automatic poke(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 32; i++) poke(5'(i), 8'h00);
    endtask

    // monitor side: release reset, then pop and compare every six edges
    task automatic run_and_monitor();
        exp_t e;
        @(negedge clk);
        check("R1 reset state", acc_out, halted, 8'h00, 1'b0);
        rst = 1'b0;
        while (sb.size() > 0) begin
            repeat (CYC_PER_INSN) @(posedge clk);
            @(negedge clk);
            e = sb.pop_front();
            check(e.req, acc_out, halted, e.acc, e.hlt);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: acc=%02h halted=%0b expected acc=-- halted=1", acc_out, halted);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // Program 1: load, add, store, reload through a zero, read back
        enter_reset();
        clear_mem();
        poke(5'd0, 8'h14);   // load 20
        poke(5'd1, 8'h55);   // add 21
        poke(5'd2, 8'h36);   // store 22
        poke(5'd3, 8'h17);   // load 23 (zero)
        poke(5'd4, 8'h16);   // load 22
        poke(5'd5, 8'hFF);   // halt
        poke(5'd20, 8'd24);
        poke(5'd21, 8'd30);
        expect_slot(8'd24, 1'b0, "R4 load");
        expect_slot(8'd54, 1'b0, "R6 add");
        expect_slot(8'd54, 1'b0, "R5 store keeps acc");
        expect_slot(8'd0,  1'b0, "R3 load zero at slot 4");
        expect_slot(8'd54, 1'b0, "R5 stored value read back");
        expect_slot(8'd54, 1'b1, "R10 halt");
        expect_slot(8'd54, 1'b1, "R10 frozen after halt");
        expect_slot(8'd54, 1'b1, "R10 still frozen");
        run_and_monitor();

        // R2: write a halt over address 0 outside reset; must be ignored
        poke(5'd0, 8'hFF);
        poke(5'd0, 8'hFF);
        enter_reset();
        expect_slot(8'd24, 1'b0, "R2 preload ignored outside reset");
        expect_slot(8'd54, 1'b0, "R1 memory kept across reset");
        run_and_monitor();

        // Program 2: shifts, complement, carry loss, branches
        enter_reset();
        clear_mem();
        poke(5'd0,  8'h14);  // load 20 -> 96
        poke(5'd1,  8'hA0);  // shl -> 2C
        poke(5'd2,  8'hC0);  // shr -> 16
        poke(5'd3,  8'h75);  // inv 21 -> F0
        poke(5'd4,  8'h56);  // add 22 -> 10
        poke(5'd5,  8'h88);  // branch to 8 (taken)
        poke(5'd6,  8'hFF);
        poke(5'd7,  8'hFF);
        poke(5'd8,  8'h77);  // inv 23 -> FF
        poke(5'd9,  8'h8C);  // branch to 12 (not taken)
        poke(5'd10, 8'hC0);  // shr -> 7F
        poke(5'd11, 8'hFF);
        poke(5'd12, 8'hFF);
        poke(5'd20, 8'h96);
        poke(5'd21, 8'h0F);
        poke(5'd22, 8'h20);
        expect_slot(8'h96, 1'b0, "R4 load pattern");
        expect_slot(8'h2C, 1'b0, "R9 shl drops msb, zero lsb");
        expect_slot(8'h16, 1'b0, "R9 shr zero msb");
        expect_slot(8'hF0, 1'b0, "R7 complement");
        expect_slot(8'h10, 1'b0, "R6 carry discarded");
        expect_slot(8'h10, 1'b0, "R8 branch taken slot");
        expect_slot(8'hFF, 1'b0, "R8 taken branch reached target");
        expect_slot(8'hFF, 1'b0, "R8 negative branch slot");
        expect_slot(8'h7F, 1'b0, "R8 not-taken falls through");
        expect_slot(8'h7F, 1'b1, "R10 halt after branch test");
        expect_slot(8'h7F, 1'b1, "R10 frozen");
        run_and_monitor();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule